// File: doc/BRIEF.md
# Reference and Loop Divider Core with Phase Comparison

This block sits between the frequency-synthesiser control registers and the analog charge pump. It divides a reference clock by a ratio taken from a small table and divides the prescaled oscillator clock by a programmable scaling word. It compares the two divided edges in a two-flop phase/frequency detector and reports lock when the loop settles. Which table applies, and how wide the scaling word may be, depend on the bus mode that programmed the device: two-wire or three-wire.

Control inputs can silence the detector and float the pump. They can also turn off the loop amplifier, which suspends the loop so the tuning voltage can be forced from outside. A test enable brings both divided pulse trains out to pins, so each division can be measured directly. A new ratio or word never cuts a cycle short. Each counter picks up the new value only when its current count runs out.

Top module: `synth_divider_core`

## Requirements
- R1: With `wire3_mode` = 0, `rd_sel` selects the reference ratio: 2'b10 gives 256, 2'b11 gives 512, 2'b00 gives 1024, and 2'b01 stops the reference divider so that no FR pulse appears. In this mode `rds` has no effect.
- R2: With `wire3_mode` = 1 and `rds` = 0, `rd_sel` values 2'b00, 2'b01, 2'b10 and 2'b11 give reference ratios 280, 50, 500 and 100.
- R3: With `wire3_mode` = 1 and `rds` = 1, each ratio is half of its R2 value: 140, 25, 250 and 50.
- R4: FP pulses repeat every N oscillator clocks. N is `div_word` in two-wire mode and `div_word` with bit 14 forced to zero in three-wire mode. An N of 0 or 1 produces no FP pulse.
- R5: With `test_en` = 1, `test_fr` and `test_fp` carry the divided pulses, each one clock wide. With `test_en` = 0, both stay low.
- R6: While `cp_off` = 1, `pump_up` and `pump_dn` stay low, `pump_hiz` is high and `lock` is low.
- R7: While `amp_off` = 1, `amp_en` is low, `pump_up` and `pump_dn` stay low, `pump_hiz` is high and `lock` is low.
- R8: An FR edge raises `pump_up` and an FP edge raises `pump_dn`. When both are high, both clear at once, so they are never seen high together. If FR runs faster, only `pump_up` ever shows high. If FP runs faster, only `pump_dn` ever shows high.
- R9: `lock` rises after 16 consecutive FR comparison periods in which `pump_up | pump_dn` never stays high for 2 reference clocks in a row. It falls on the first reference clock that breaks that limit.
- R10: A change of reference ratio or scaling word takes effect at the divider's next terminal count, so the period already running completes at the old length.
- R11: While `rst_n` is low, `pump_up`, `pump_dn`, `lock`, `test_fr` and `test_fp` are low, `amp_en` is high, and `pump_hiz` follows `cp_off | amp_off`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock |
| vco_clk | input | 1 | Prescaled oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_word | input | 15 | Loop scaling word |
| rd_sel | input | 2 | Reference ratio code, bit 1 high code bit |
| rds | input | 1 | Three-wire halving select |
| wire3_mode | input | 1 | 1 = three-wire bus mode, 0 = two-wire mode |
| cp_off | input | 1 | Pump disable |
| test_en | input | 1 | Route divided pulses to test pins |
| amp_off | input | 1 | Loop amplifier disable |
| pump_up | output | 1 | Pump source enable |
| pump_dn | output | 1 | Pump sink enable |
| pump_hiz | output | 1 | Pump output float request |
| amp_en | output | 1 | Loop amplifier enable |
| lock | output | 1 | Loop in lock |
| test_fr | output | 1 | Divided reference pulse on test pin |
| test_fp | output | 1 | Divided loop pulse on test pin |

## Verification
The bench uses the default parameters: a 15-bit word, 16 lock periods and a 2-cycle window. It runs both clocks at one period and phase, so equal ratios make FR and FP coincide exactly. This brings lock within about four thousand cycles and gives predictable pulse widths when the ratios differ. Every reference code in both modes and both `rds` levels is measured in turn. A set of scaling words, including the dead values 0 and 1 and words with bit 14 set, is measured the same way.

// File: rtl/synth_div_pkg.sv
package synth_div_pkg;
  localparam int REF_W = 11;
  typedef logic [REF_W-1:0] ref_ratio_t;

  // Reference ratio chosen by bus mode, halving select and two code bits; zero means stopped.
  function automatic ref_ratio_t ratio_lookup(input logic three_wire, input logic half_rate,
                                              input logic [1:0] code);
    ref_ratio_t r;
    if (!three_wire) begin
      case (code)
        2'b00:   r = ref_ratio_t'(1024);
        2'b01:   r = '0;
        2'b10:   r = ref_ratio_t'(256);
        default: r = ref_ratio_t'(512);
      endcase
    end else begin
      case (code)
        2'b00:   r = ref_ratio_t'(280);
        2'b01:   r = ref_ratio_t'(50);
        2'b10:   r = ref_ratio_t'(500);
        default: r = ref_ratio_t'(100);
      endcase
      if (half_rate) r = r >> 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/synth_modn_divider.sv
module synth_modn_divider #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ratio,
  output logic         tc
);
  logic [W-1:0] cnt;
  logic         run_q;
  logic         ratio_ok;

  assign ratio_ok = (ratio > W'(1));

  // Count down N-1..0; the new ratio is taken only when the count is exhausted.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      run_q <= 1'b0;
      tc    <= 1'b0;
    end else begin
      tc <= (cnt == '0) && run_q;
      if (cnt == '0) begin
        run_q <= ratio_ok;
        cnt   <= ratio_ok ? (ratio - W'(1)) : '0;
      end else begin
        cnt <= cnt - W'(1);
      end
    end
  end
endmodule

// File: rtl/synth_pfd.sv
module synth_pfd (
  input  logic rst_n,
  input  logic hold,
  input  logic fr,
  input  logic fp,
  output logic up,
  output logic dn
);
  logic clr;

  assign clr = !rst_n || hold || (up && dn);

  always_ff @(posedge fr or posedge clr) begin
    if (clr) up <= 1'b0;
    else     up <= 1'b1;
  end

  always_ff @(posedge fp or posedge clr) begin
    if (clr) dn <= 1'b0;
    else     dn <= 1'b1;
  end
endmodule

// File: rtl/synth_lock_monitor.sv
module synth_lock_monitor #(
  parameter int CYCLES = 16,
  parameter int WIN    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic cmp_tick,
  input  logic busy,
  output logic locked
);
  localparam int GW = $clog2(CYCLES + 1);
  localparam int WW = $clog2(WIN + 1);

  logic [GW-1:0] good;
  logic [WW-1:0] width;
  logic          viol;

  // width holds the busy samples already seen in a row; this sample makes one more.
  assign viol = busy && (width >= WW'(WIN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      good   <= '0;
      width  <= '0;
      locked <= 1'b0;
    end else if (hold) begin
      good   <= '0;
      width  <= '0;
      locked <= 1'b0;
    end else begin
      if (!busy)                   width <= '0;
      else if (width != WW'(WIN))  width <= width + WW'(1);
      if (viol) begin
        good   <= '0;
        locked <= 1'b0;
      end else if (cmp_tick) begin
        if (good != GW'(CYCLES))     good   <= good + GW'(1);
        if (good >= GW'(CYCLES - 1)) locked <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/synth_divider_core.sv
module synth_divider_core #(
  parameter int SF_W        = 15,
  parameter int LOCK_CYCLES = 16,
  parameter int LOCK_WIN    = 2
) (
  input  logic            ref_clk,
  input  logic            vco_clk,
  input  logic            rst_n,
  input  logic [SF_W-1:0] div_word,
  input  logic [1:0]      rd_sel,
  input  logic            rds,
  input  logic            wire3_mode,
  input  logic            cp_off,
  input  logic            test_en,
  input  logic            amp_off,
  output logic            pump_up,
  output logic            pump_dn,
  output logic            pump_hiz,
  output logic            amp_en,
  output logic            lock,
  output logic            test_fr,
  output logic            test_fp
);
  localparam logic [SF_W-1:0] W3_MASK = {1'b0, {(SF_W-1){1'b1}}};

  synth_div_pkg::ref_ratio_t ref_ratio;
  logic [SF_W-1:0]           loop_ratio;
  logic                      fr_tick;
  logic                      fp_tick;
  logic                      pfd_hold;

  assign ref_ratio  = synth_div_pkg::ratio_lookup(wire3_mode, rds, rd_sel);
  assign loop_ratio = wire3_mode ? (div_word & W3_MASK) : div_word;
  assign pfd_hold   = cp_off | amp_off;

  synth_modn_divider #(.W(synth_div_pkg::REF_W)) u_ref_div (
    .clk(ref_clk), .rst_n(rst_n), .ratio(ref_ratio), .tc(fr_tick)
  );

  synth_modn_divider #(.W(SF_W)) u_loop_div (
    .clk(vco_clk), .rst_n(rst_n), .ratio(loop_ratio), .tc(fp_tick)
  );

  synth_pfd u_pfd (
    .rst_n(rst_n), .hold(pfd_hold), .fr(fr_tick), .fp(fp_tick),
    .up(pump_up), .dn(pump_dn)
  );

  synth_lock_monitor #(.CYCLES(LOCK_CYCLES), .WIN(LOCK_WIN)) u_lock (
    .clk(ref_clk), .rst_n(rst_n), .hold(pfd_hold), .cmp_tick(fr_tick),
    .busy(pump_up | pump_dn), .locked(lock)
  );

  assign pump_hiz = pfd_hold;
  assign amp_en   = !amp_off;
  assign test_fr  = test_en & fr_tick;
  assign test_fp  = test_en & fp_tick;
endmodule

// File: rtl/synth_divider_core_chk.sv
module synth_divider_core_chk (
  input logic ref_clk,
  input logic rst_n,
  input logic cp_off,
  input logic amp_off,
  input logic test_en,
  input logic pump_up,
  input logic pump_dn,
  input logic pump_hiz,
  input logic amp_en,
  input logic lock,
  input logic test_fr,
  input logic test_fp
);
  AST_PUMP_SILENT: assert property (@(posedge ref_clk) disable iff (!rst_n)
    cp_off |-> (!pump_up && !pump_dn && pump_hiz)); // R6

  AST_AMP_SUSPEND: assert property (@(posedge ref_clk) disable iff (!rst_n)
    amp_off |-> (!amp_en && !pump_up && !pump_dn)); // R7

  AST_NO_DUAL_PUMP: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !(pump_up && pump_dn)); // R8

  AST_LOCK_ENTRY: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(lock) |-> (!$past(cp_off) && !$past(amp_off))); // R9

  AST_TEST_IDLE: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !test_en |-> (!test_fr && !test_fp)); // R5
endmodule

bind synth_divider_core synth_divider_core_chk u_chk (
  .ref_clk(ref_clk), .rst_n(rst_n), .cp_off(cp_off), .amp_off(amp_off),
  .test_en(test_en), .pump_up(pump_up), .pump_dn(pump_dn), .pump_hiz(pump_hiz),
  .amp_en(amp_en), .lock(lock), .test_fr(test_fr), .test_fp(test_fp)
);

// File: tb/synth_divider_core_tb.sv
module synth_divider_core_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SF_W       = 15;
  localparam int WATCHDOG   = 190000;
  localparam int LIMIT      = 2200;

  logic            ref_clk = 1'b0;
  logic            vco_clk = 1'b0;
  logic            rst_n   = 1'b0;
  logic [SF_W-1:0] div_word = 15'd256;
  logic [1:0]      rd_sel = 2'b10;
  logic            rds = 1'b0, wire3_mode = 1'b0, cp_off = 1'b0, test_en = 1'b1, amp_off = 1'b0;
  logic            pump_up, pump_dn, pump_hiz, amp_en, lock, test_fr, test_fp;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) ref_clk = ~ref_clk;
  always #(CLK_PERIOD/2) vco_clk = ~vco_clk;

  synth_divider_core u_dut (
    .ref_clk(ref_clk), .vco_clk(vco_clk), .rst_n(rst_n), .div_word(div_word),
    .rd_sel(rd_sel), .rds(rds), .wire3_mode(wire3_mode), .cp_off(cp_off),
    .test_en(test_en), .amp_off(amp_off), .pump_up(pump_up), .pump_dn(pump_dn),
    .pump_hiz(pump_hiz), .amp_en(amp_en), .lock(lock), .test_fr(test_fr), .test_fp(test_fp)
  );

  always @(posedge ref_clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cycles, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic apply_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge ref_clk);
    rst_n = 1'b1;
  endtask

  function automatic logic pick(input bit use_fp);
    return use_fp ? test_fp : test_fr;
  endfunction

  // Clocks between two successive pulses; 0 when none arrives within LIMIT.
  task automatic period_of(input bit use_fp, output int per);
    int n = 0;
    per = 0;
    while (pick(use_fp) !== 1'b1 && n < LIMIT) begin
      @(negedge ref_clk);
      n++;
    end
    if (n >= LIMIT) return;
    n = 0;
    do begin
      @(negedge ref_clk);
      n++;
    end while (pick(use_fp) !== 1'b1 && n < LIMIT);
    per = (n < LIMIT) ? n : 0;
  endtask

  task automatic watch(input int n, output bit up_seen, output bit dn_seen, output bit tst_seen);
    up_seen = 0; dn_seen = 0; tst_seen = 0;
    repeat (n) begin
      @(negedge ref_clk);
      if (pump_up) up_seen = 1;
      if (pump_dn) dn_seen = 1;
      if (test_fr || test_fp) tst_seen = 1;
    end
  endtask

  function automatic int exp_ref(input bit w3, input bit half, input bit [1:0] code);
    int base;
    if (!w3) begin
      if (code == 2'b01) return 0;
      if (code == 2'b00) return 1024;
      return 256 << code[0];
    end
    base = (code == 2'd0) ? 280 : (code == 2'd1) ? 50 : (code == 2'd2) ? 500 : 100;
    return half ? base / 2 : base;
  endfunction

  initial begin
    int per;
    bit u, d, t;
    int words [11] = '{2, 3, 5, 256, 300, 1000, 0, 1, 16384 + 7, 16384 + 300, 9};
    bit w3s  [11] = '{0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 1};

    // R11 reset state
    repeat (2) @(negedge ref_clk);
    check("R11", "pump_up in reset", pump_up, 0);
    check("R11", "pump_dn in reset", pump_dn, 0);
    check("R11", "lock in reset", lock, 0);
    check("R11", "test pins in reset", test_fr | test_fp, 0);
    check("R11", "amp_en in reset", amp_en, 1);
    check("R11", "pump_hiz in reset", pump_hiz, 0);

    // R1 R2 R3 reference ratio sweep
    for (int w = 0; w < 2; w++)
      for (int h = 0; h < 2; h++)
        for (int c = 0; c < 4; c++) begin
          wire3_mode = w[0]; rds = h[0]; rd_sel = c[1:0];
          apply_reset();
          period_of(0, per);
          check(w == 0 ? "R1" : (h == 0 ? "R2" : "R3"), "reference period", per,
                exp_ref(w[0], h[0], c[1:0]));
        end

    // R4 loop divider
    rd_sel = 2'b10; rds = 1'b0;
    for (int i = 0; i < 11; i++) begin
      int m;
      wire3_mode = w3s[i];
      div_word = SF_W'(words[i]);
      m = w3s[i] ? (words[i] & 16'h3FFF) : words[i];
      apply_reset();
      period_of(1, per);
      check("R4", "loop period", per, (m < 2) ? 0 : m);
    end

    // R5 test pins gated
    wire3_mode = 1'b0; div_word = 15'd256; test_en = 1'b0;
    apply_reset();
    watch(1500, u, d, t);
    check("R5", "test pins with test_en low", t, 0);
    test_en = 1'b1;

    // R8 detector direction
    apply_reset();
    watch(3000, u, d, t);
    check("R8", "up seen when matched", u, 0);
    check("R8", "dn seen when matched", d, 0);
    div_word = 15'd300;
    apply_reset();
    watch(3000, u, d, t);
    check("R8", "up seen, FR faster", u, 1);
    check("R8", "dn seen, FR faster", d, 0);
    div_word = 15'd200;
    apply_reset();
    watch(3000, u, d, t);
    check("R8", "up seen, FP faster", u, 0);
    check("R8", "dn seen, FP faster", d, 1);

    // R9 lock timing, R6 R7 holds
    div_word = 15'd256;
    apply_reset();
    repeat (16 * 256 - 20) @(negedge ref_clk);
    check("R9", "lock before 16 periods", lock, 0);
    repeat (40) @(negedge ref_clk);
    check("R9", "lock after 16 periods", lock, 1);
    cp_off = 1'b1;
    @(negedge ref_clk);
    check("R6", "lock under cp_off", lock, 0);
    check("R6", "pump_hiz under cp_off", pump_hiz, 1);
    cp_off = 1'b0;
    repeat (17 * 256 + 10) @(negedge ref_clk);
    check("R9", "relock after cp_off", lock, 1);
    amp_off = 1'b1;
    @(negedge ref_clk);
    check("R7", "lock under amp_off", lock, 0);
    check("R7", "amp_en under amp_off", amp_en, 0);
    amp_off = 1'b0;
    repeat (17 * 256 + 10) @(negedge ref_clk);
    check("R9", "relock after amp_off", lock, 1);
    div_word = 15'd300;
    repeat (700) @(negedge ref_clk);
    check("R9", "lock lost on mismatch", lock, 0);
    cp_off = 1'b1;
    watch(1200, u, d, t);
    check("R6", "pump active under cp_off", u | d, 0);
    check("R6", "pump_hiz held", pump_hiz, 1);
    cp_off = 1'b0;
    amp_off = 1'b1;
    watch(1200, u, d, t);
    check("R7", "pump active under amp_off", u | d, 0);
    check("R7", "pump_hiz under amp_off", pump_hiz, 1);
    amp_off = 1'b0;
    watch(1200, u, d, t);
    check("R8", "up resumes after release", u, 1);

    // R10 changes wait for terminal count
    div_word = 15'd256; rd_sel = 2'b10;
    apply_reset();
    period_of(0, per);
    check("R10", "reference base period", per, 256);
    rd_sel = 2'b11;
    period_of(0, per);
    check("R10", "period in flight keeps old ratio", per, 256);
    period_of(0, per);
    check("R10", "next period uses new ratio", per, 512);
    apply_reset();
    period_of(1, per);
    check("R10", "loop base period", per, 256);
    div_word = 15'd100;
    period_of(1, per);
    check("R10", "loop period in flight keeps old word", per, 256);
    period_of(1, per);
    check("R10", "loop next period uses new word", per, 100);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule